// File: doc/BRIEF.md
# Key-Sequence Software Watchdog

This block is a watchdog that software must keep alive by writing an ordered pair of key bytes to a service register. Once the pair is complete, the tick counter restarts from zero. If the counter instead reaches the selected period, the block drives a one-cycle reset pulse. After the pulse it returns its control state to the defaults.

Software reaches the block through a small register port with two addresses. Address 0 is the control word, which holds the enable, the prescale choice and the period select. Address 1 is the service register. The counter advances only on cycles where the reference tick input is high.

The period is a power of two of ticks. Three parameters set its base, its step per select value and the prescale factor. A newly written period select is not used until the next completed service. The prescale bit comes out of reset as the inverse of a mode pin, sampled while reset is held.

Top module: `keyseq_wdog`

## Requirements
- R1: While `rst_n` is low (synchronous reset), the control word is reset to enable=1 (bit 7) and select=0 (bits 1:0). The prescale bit (bit 4) becomes the inverse of `mode_pin`, and `wdog_rst` is low.
- R2: The period is L = P * 2^(BASE_LOG2 + STEP_LOG2*s) ticks. Here s is the active select, and P is 2^PRE_LOG2 when the prescale bit is 1, otherwise 1. After a restart, `wdog_rst` is seen in the cycle after the edge that counts the L-th tick.
- R3: On the service address (1), ARM_KEY (0x55) arms the sequence, and FIRE_KEY (0xAA) while armed restarts the count from zero and disarms. FIRE_KEY while not armed is ignored. Other values, repeated ARM_KEY writes and writes to the control address leave the armed state as it is.
- R4: A select value written to the control word takes effect only at the next completed service. Until then the period in force stays unchanged.
- R5: While the enable bit is 0, the count holds and `wdog_rst` stays low.
- R6: A read of the service address returns zero. A read of the control address returns the fields as written.
- R7: `wdog_rst` lasts exactly one cycle. In that cycle the count is zero, the sequence is disarmed, the enable bit is 1, and the written and active selects are 0. The prescale bit is kept.
- R8: The count advances only on cycles where `tick` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Reference tick enable |
| mode_pin | input | 1 | Mode pin sampled during reset for the prescale default |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 control, 1 service |
| wr_data | input | DW | Write data |
| rd_addr | input | 1 | Read address: 0 control, 1 service |
| rd_data | output | DW | Read data (combinational) |
| wdog_rst | output | 1 | One-cycle timeout reset pulse |

## Verification
The bound checker checks the following on every cycle:
- the pulse lasts one cycle;
- state is reinitialised during the pulse;
- a disabled counter stays quiet;
- the count is held on cycles with no tick;
- a completed service clears the count;
- the active select is held between services;
- the service register reads zero.

The exact period for each prescale and select pair, and the order rules of the key sequence, can only be shown by the bench's scenarios. The same applies to the delayed use of a new select and to the prescale default set by the mode pin. For these the bench measures pulse distances in cycles against arithmetic expectations.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int EN_BIT  = 7;
   localparam int PRE_BIT = 4;
   localparam int SEL_W   = 2;
   localparam int N_SEL   = 1 << SEL_W;

   typedef enum logic {
      ADDR_CTRL = 1'b0,
      ADDR_SVC  = 1'b1
   } wdog_addr_e;
endpackage

// File: rtl/wdog_key_seq.sv
module wdog_key_seq #(
   parameter int          DW       = 8,
   parameter logic [DW-1:0] ARM_KEY  = 8'h55,
   parameter logic [DW-1:0] FIRE_KEY = 8'hAA
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          wr,
   input  logic [DW-1:0] data,
   output logic          armed,
   output logic          done
);
   assign done = wr && armed && (data == FIRE_KEY);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         armed <= 1'b0;
      end else if (wr) begin
         if (data == ARM_KEY)       armed <= 1'b1;
         else if (data == FIRE_KEY) armed <= 1'b0;
      end
   end
endmodule

// File: rtl/wdog_period.sv
module wdog_period #(
   parameter int PRE_LOG2  = 9,
   parameter int BASE_LOG2 = 9,
   parameter int STEP_LOG2 = 2,
   parameter int CW        = 24
) (
   input  logic                    pre,
   input  logic [wdog_pkg::SEL_W-1:0] sel,
   output logic [CW-1:0]           last
);
   import wdog_pkg::*;
   localparam int SW = $clog2(CW + 1);

   logic [SW-1:0] sh_sel [N_SEL];
   logic [SW-1:0] sh;
   logic [CW:0]   full;
   logic          unused_msb;

   for (genvar g = 0; g < N_SEL; g++) begin : g_sel
      assign sh_sel[g] = SW'(BASE_LOG2 + STEP_LOG2 * g);
   end

   if (PRE_LOG2 > 0) begin : g_pre
      assign sh = sh_sel[sel] + (pre ? SW'(PRE_LOG2) : '0);
   end else begin : g_nopre
      logic unused_pre;
      assign unused_pre = pre;
      assign sh = sh_sel[sel];
   end

   assign full       = ({{CW{1'b0}}, 1'b1} << sh) - 1'b1;
   assign last       = full[CW-1:0];
   assign unused_msb = full[CW];
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int CW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          tick,
   input  logic          clear,
   input  logic [CW-1:0] last,
   output logic [CW-1:0] cnt,
   output logic          hit,
   output logic          pulse
);
   assign hit = en && tick && (cnt >= last);

   always_ff @(posedge clk) begin
      if (!rst_n || clear || hit) cnt <= '0;
      else if (en && tick)        cnt <= cnt + 1'b1;
      pulse <= rst_n && hit;
   end
endmodule

// File: rtl/keyseq_wdog.sv
module keyseq_wdog #(
   parameter int            DW        = 8,
   parameter int            PRE_LOG2  = 9,
   parameter int            BASE_LOG2 = 9,
   parameter int            STEP_LOG2 = 2,
   parameter logic [DW-1:0] ARM_KEY   = 8'h55,
   parameter logic [DW-1:0] FIRE_KEY  = 8'hAA
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          mode_pin,
   input  logic          wr_en,
   input  logic          wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_addr,
   output logic [DW-1:0] rd_data,
   output logic          wdog_rst
);
   import wdog_pkg::*;
   localparam int CW = PRE_LOG2 + BASE_LOG2 + STEP_LOG2 * (N_SEL - 1) + 1;

   initial begin
      assert (DW > EN_BIT && DW > PRE_BIT) else $error("DW too narrow for control fields");
      assert (PRE_LOG2 >= 0 && BASE_LOG2 >= 1 && STEP_LOG2 >= 0) else $error("bad period parameters");
      assert (ARM_KEY != FIRE_KEY) else $error("keys must differ");
   end

   logic                swe_q, swp_q;
   logic [SEL_W-1:0]    swt_q, act_q;
   logic                ctrl_wr, svc_wr, svc_done, armed, hit;
   logic [CW-1:0]       cnt, last;

   assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
   assign svc_wr  = wr_en && (wr_addr == ADDR_SVC);

   wdog_key_seq #(.DW(DW), .ARM_KEY(ARM_KEY), .FIRE_KEY(FIRE_KEY)) u_key (
      .clk(clk), .rst_n(rst_n), .clr(hit), .wr(svc_wr), .data(wr_data),
      .armed(armed), .done(svc_done)
   );

   wdog_period #(.PRE_LOG2(PRE_LOG2), .BASE_LOG2(BASE_LOG2),
                 .STEP_LOG2(STEP_LOG2), .CW(CW)) u_per (
      .pre(swp_q), .sel(act_q), .last(last)
   );

   wdog_counter #(.CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en(swe_q), .tick(tick), .clear(svc_done),
      .last(last), .cnt(cnt), .hit(hit), .pulse(wdog_rst)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         swe_q <= 1'b1;
         swp_q <= ~mode_pin;
         swt_q <= '0;
         act_q <= '0;
      end else if (hit) begin
         swe_q <= 1'b1;
         swt_q <= '0;
         act_q <= '0;
      end else begin
         if (ctrl_wr) begin
            swe_q <= wr_data[EN_BIT];
            swp_q <= wr_data[PRE_BIT];
            swt_q <= wr_data[SEL_W-1:0];
         end
         if (svc_done) act_q <= swt_q;
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_CTRL) begin
         rd_data[EN_BIT]      = swe_q;
         rd_data[PRE_BIT]     = swp_q;
         rd_data[SEL_W-1:0]   = swt_q;
      end
   end
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
   parameter int CW = 24,
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tick,
   input logic          wdog_rst,
   input logic          en,
   input logic          armed,
   input logic [CW-1:0] cnt,
   input logic [1:0]    act,
   input logic [1:0]    swt,
   input logic          hit,
   input logic          svc_done,
   input logic          rd_addr,
   input logic [DW-1:0] rd_data
);
   p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_rst |=> !wdog_rst);

   p_reinit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_rst |-> (cnt == '0 && en && !armed && act == 2'd0 && swt == 2'd0));

   p_quiet_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !wdog_rst);

   p_hold_no_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !svc_done) |=> $stable(cnt));

   p_service_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      svc_done |=> (cnt == '0));

   p_select_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!svc_done && !hit) |=> $stable(act));

   p_service_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_addr |-> (rd_data == '0));
endmodule

bind keyseq_wdog wdog_chk #(.CW(CW), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .wdog_rst(wdog_rst), .en(swe_q),
   .armed(armed), .cnt(cnt), .act(act_q), .swt(swt_q), .hit(hit),
   .svc_done(svc_done), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/tb_keyseq_wdog.sv
module tb_keyseq_wdog;
   localparam int CLK_PERIOD = 10;
   localparam int PRE  = 2;
   localparam int BASE = 3;
   localparam int STEP = 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       mode_pin = 1'b1;
   logic       wr_en = 1'b0;
   logic       wr_addr = 1'b0;
   logic [7:0] wr_data = '0;
   logic       rd_addr = 1'b0;
   logic [7:0] rd_data;
   logic       wdog_rst;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   keyseq_wdog #(.DW(8), .PRE_LOG2(PRE), .BASE_LOG2(BASE), .STEP_LOG2(STEP)) dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .mode_pin(mode_pin),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .wdog_rst(wdog_rst)
   );

   function automatic int exp_len(input int swp, input int sel);
      return (swp != 0 ? (1 << PRE) : 1) << (BASE + STEP * sel);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic wr(input logic a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic a, output int v);
      rd_addr = a;
      #1 v = int'(rd_data);
   endtask

   task automatic service();
      wr(1'b1, 8'h55);
      wr(1'b1, 8'hAA);
   endtask

   task automatic wait_pulse(input int max, output int n);
      n = 0;
      while (n < max) begin
         @(posedge clk); n++;
         @(negedge clk);
         if (wdog_rst) return;
      end
      n = -1;
   endtask

   task automatic quiet(input int cyc, output int pulses);
      pulses = 0;
      repeat (cyc) begin
         @(posedge clk); @(negedge clk);
         if (wdog_rst) pulses++;
      end
   endtask

   task automatic do_reset(input logic mp);
      rst_n = 1'b0; mode_pin = mp;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int v, n, p;
      @(negedge clk);
      do_reset(1'b1);
      // R1: reset state with mode_pin high -> prescale 0
      rd(1'b0, v);
      check(v == 8'h80, "R1 ctrl after reset", v, 8'h80);
      check(wdog_rst == 1'b0, "R1 pulse low", int'(wdog_rst), 0);

      // R8: no ticks, no progress
      quiet(100, p);
      check(p == 0, "R8 no pulse without tick", p, 0);
      tick = 1'b1;

      // R2 sweep over prescale and select
      for (int swp = 0; swp < 2; swp++) begin
         for (int sel = 0; sel < 4; sel++) begin
            wr(1'b0, 8'h80 | 8'(swp << 4) | 8'(sel));
            service();
            wait_pulse(2000, n);
            check(n == exp_len(swp, sel), "R2 period", n, exp_len(swp, sel));
            rd(1'b0, v);
            check(v == (8'h80 | (swp << 4)), "R7 reinit ctrl", v, 8'h80 | (swp << 4));
            @(posedge clk); @(negedge clk);
            check(wdog_rst == 1'b0, "R7 single cycle pulse", int'(wdog_rst), 0);
         end
      end

      // R4: select written after service is not used yet
      wr(1'b0, 8'h80);
      service();
      wr(1'b0, 8'h83);
      wait_pulse(2000, n);
      check(n == exp_len(0, 0) - 1, "R4 old period kept", n, exp_len(0, 0) - 1);
      wr(1'b0, 8'h83);
      service();
      wait_pulse(2000, n);
      check(n == exp_len(0, 3), "R4 new period after service", n, exp_len(0, 3));

      // R3: lone FIRE_KEY ignored, other value ignored
      service();
      wr(1'b1, 8'hAA);
      wr(1'b1, 8'h12);
      wait_pulse(2000, n);
      check(n == exp_len(0, 0) - 2, "R3 lone AA ignored", n, exp_len(0, 0) - 2);

      // R3: activity between keys, repeated ARM_KEY
      wr(1'b1, 8'h55);
      wr(1'b1, 8'h12);
      wr(1'b0, 8'h80);
      wr(1'b1, 8'h55);
      wr(1'b1, 8'hAA);
      wait_pulse(2000, n);
      check(n == exp_len(0, 0), "R3 restart after gap", n, exp_len(0, 0));

      // R6: service register reads zero
      wr(1'b1, 8'h55);
      rd(1'b1, v);
      check(v == 0, "R6 service reads zero", v, 0);
      rd(1'b0, v);
      check(v == 8'h80, "R6 ctrl readback", v, 8'h80);

      // R5: disabled -> no pulse
      wr(1'b0, 8'h00);
      rd(1'b0, v);
      check(v == 8'h00, "R5 enable cleared", v, 0);
      quiet(300, p);
      check(p == 0, "R5 no pulse while disabled", p, 0);
      wr(1'b0, 8'h80);
      service();
      wait_pulse(2000, n);
      check(n == exp_len(0, 0), "R5 re-enabled period", n, exp_len(0, 0));

      // R8: tick gaps stall the count
      service();
      tick = 1'b0;
      quiet(50, p);
      check(p == 0, "R8 stalled without tick", p, 0);
      tick = 1'b1;
      wait_pulse(2000, n);
      check(n == exp_len(0, 0), "R8 resumes on tick", n, exp_len(0, 0));

      // R1: mode_pin low -> prescale 1
      do_reset(1'b0);
      rd(1'b0, v);
      check(v == 8'h90, "R1 prescale from mode pin", v, 8'h90);
      service();
      wait_pulse(2000, n);
      check(n == exp_len(1, 0), "R1 prescaled period", n, exp_len(1, 0));

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule